// File: doc/BRIEF.md
# UART Buffer Status and Flush Controller

This block holds the transmit and receive byte queues of a UART and presents them to software through one 8-bit status/control register. The register reports occupancy flags for both queues. It latches a sticky error when the transmit side is written while full. It lets software discard either queue by writing a one to that queue's empty flag. A transmit discard also tells the serial shifter to drop the byte it is holding.

On the transmit side, bytes are handed to an external shifter. A one-cycle load strobe is issued whenever a byte is waiting and the shifter reports ready. On the receive side, an external receiver pushes bytes in and software pops them. The same external receiver supplies three stop-bit timing strobes: middle of first stop bit, end of first stop bit and end of last stop bit. A register mode bit and a 2-bit stop configuration choose which of them raises the receive interrupt.

Top module: `uart_bufctl`

## Requirements
- R1: After reset the register reads 8'h2E. The fields, from bit 7 down to bit 0, are: write error, stop-detect mode, TX empty, TX full, RX line idle, transmitter enabled, RX empty, RX full.
- R2: Each queue holds 2 bytes. Bit 5 is 1 when the TX queue holds no byte, and bit 4 is 1 when it holds 2 bytes.
- R3: A transmit write while the TX queue is full is dropped and sets bit 7 from the next cycle on. Bit 7 then stays 1 until a register write stores 0 into it; a same-cycle overflow takes priority over that write.
- R4: A register write with bit 5 = 1 empties the TX queue and drives shf_clear high in that same cycle, with no load in that cycle. A write with bit 5 = 0 leaves the TX queue unchanged.
- R5: When the TX queue is not empty and shf_ready is 1, shf_load is 1 in that cycle, shf_data carries the oldest byte, and that byte leaves the queue. Bytes leave in write order.
- R6: Bit 1 is 1 when the RX queue is empty and bit 0 is 1 when it holds 2 bytes. rx_data shows the oldest byte, and rx_rd removes it. A push into a full RX queue is dropped and the stored bytes are kept.
- R7: A register write with bit 1 = 1 empties the RX queue. A write with bit 1 = 0 leaves it unchanged.
- R8: rx_irq is the selected stop strobe delayed by one cycle. With bit 6 = 0 it follows stb_mid_first. With bit 6 = 1 and stop_cfg = 2'b11 it follows stb_end_first. With bit 6 = 1 and any other stop_cfg it follows stb_end_last.
- R9: Bit 3 follows rx_pin_idle and bit 2 follows flow_xon, each one cycle late. Register writes to bits 4, 3, 2 and 0 have no effect.
- R10: Bit 6 is read/write storage that takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Transmit byte |
| shf_ready | input | 1 | Shifter can accept a byte |
| shf_load | output | 1 | One-cycle load strobe to shifter |
| shf_data | output | 8 | Byte handed to shifter |
| shf_clear | output | 1 | Shifter discard strobe |
| rx_push | input | 1 | Receiver byte push strobe |
| rx_push_data | input | 8 | Received byte |
| rx_rd | input | 1 | Receive byte read strobe |
| rx_data | output | 8 | Oldest received byte |
| rx_pin_idle | input | 1 | Receive line is idle |
| flow_xon | input | 1 | Transmitter enabled by flow control |
| stop_cfg | input | 2 | Stop-bit configuration |
| stb_mid_first | input | 1 | Middle of first stop bit strobe |
| stb_end_first | input | 1 | End of first stop bit strobe |
| stb_end_last | input | 1 | End of last stop bit strobe |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench targets several corner cases:
- A transmit write that meets a full queue at the same time as a load. A design that decides fullness after the pop would accept the byte instead of flagging an error.
- A discard write in the same cycle as a write, a push or a load. A wrong priority would leave a byte behind or still strobe the shifter.
- The receive interrupt, walked through every mode and stop-configuration pairing. A mis-decoded select would fire on the wrong strobe.
- Writes of zero to the empty flags, and writes of ones to the read-only fields. A design that stored them would corrupt the occupancy or line-status flags.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
  localparam int REG_W = 8;

  // Field positions inside the status/control register
  localparam int B_WERR     = 7;
  localparam int B_STOPMODE = 6;
  localparam int B_TXEMPTY  = 5;
  localparam int B_TXFULL   = 4;
  localparam int B_RXIDLE   = 3;
  localparam int B_TXEN     = 2;
  localparam int B_RXEMPTY  = 1;
  localparam int B_RXFULL   = 0;

  localparam logic [1:0] STOP_CFG_FIRST_END = 2'b11;

  typedef struct packed {
    logic wr_err;
    logic stop_mode;
    logic tx_empty;
    logic tx_full;
    logic rx_idle;
    logic tx_en;
    logic rx_empty;
    logic rx_full;
  } stat_t;
endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  mem_q [DEPTH];
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    ptr_inc = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign head    = mem_q[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push_ok) wptr_d = ptr_inc(wptr_q);
      if (pop_ok)  rptr_d = ptr_inc(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // Data storage: no reset, written only under its own enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = push_ok & (wptr_q == AW'(i));
    always_ff @(posedge clk) begin
      if (slot_en) mem_q[i] <= push_data;
    end
  end
endmodule

// File: rtl/ufc_status.sv
module ufc_status
  import ufc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             tx_overflow,
  input  logic             tx_full,
  input  logic             tx_empty,
  input  logic             rx_full,
  input  logic             rx_empty,
  input  logic             rx_pin_idle,
  input  logic             flow_xon,
  output logic [REG_W-1:0] reg_rdata,
  output logic             tx_flush,
  output logic             rx_flush,
  output logic             stop_mode
);
  logic werr_q, werr_d, werr_en;
  logic mode_q, mode_d, mode_en;
  logic idle_q, xon_q;
  stat_t stat;

  assign tx_flush = reg_we & reg_wdata[B_TXEMPTY];
  assign rx_flush = reg_we & reg_wdata[B_RXEMPTY];

  // Hardware set wins over a software write in the same cycle
  always_comb begin
    werr_en = tx_overflow | reg_we;
    werr_d  = tx_overflow ? 1'b1 : reg_wdata[B_WERR];
    mode_en = reg_we;
    mode_d  = reg_wdata[B_STOPMODE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      werr_q <= 1'b0;
      mode_q <= 1'b0;
      idle_q <= 1'b1;
      xon_q  <= 1'b1;
    end else begin
      if (werr_en) werr_q <= werr_d;
      if (mode_en) mode_q <= mode_d;
      idle_q <= rx_pin_idle;
      xon_q  <= flow_xon;
    end
  end

  always_comb begin
    stat.wr_err    = werr_q;
    stat.stop_mode = mode_q;
    stat.tx_empty  = tx_empty;
    stat.tx_full   = tx_full;
    stat.rx_idle   = idle_q;
    stat.tx_en     = xon_q;
    stat.rx_empty  = rx_empty;
    stat.rx_full   = rx_full;
  end

  assign reg_rdata = stat;
  assign stop_mode = mode_q;
endmodule

// File: rtl/ufc_irq_sel.sv
module ufc_irq_sel
  import ufc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_mode,
  input  logic [1:0] stop_cfg,
  input  logic       stb_mid_first,
  input  logic       stb_end_first,
  input  logic       stb_end_last,
  output logic       rx_irq
);
  logic sel_d, irq_q;

  always_comb begin
    if (!stop_mode)                        sel_d = stb_mid_first;
    else if (stop_cfg == STOP_CFG_FIRST_END) sel_d = stb_end_first;
    else                                   sel_d = stb_end_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= sel_d;
  end

  assign rx_irq = irq_q;
endmodule

// File: rtl/uart_bufctl.sv
module uart_bufctl
  import ufc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TX_DEPTH = 2,
  parameter int RX_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              shf_ready,
  output logic              shf_load,
  output logic [DATA_W-1:0] shf_data,
  output logic              shf_clear,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_push_data,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_pin_idle,
  input  logic              flow_xon,
  input  logic [1:0]        stop_cfg,
  input  logic              stb_mid_first,
  input  logic              stb_end_first,
  input  logic              stb_end_last,
  output logic              rx_irq
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rsync_q;
  logic srst_n;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_flush, rx_flush, stop_mode;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RST_STAGES-2:0], 1'b1};
  end
  assign srst_n = rsync_q[RST_STAGES-1];

  ufc_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(srst_n), .flush(tx_flush),
    .push(tx_wr), .push_data(tx_data), .pop(shf_ready),
    .head(shf_data), .full(tx_full), .empty(tx_empty)
  );

  ufc_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(srst_n), .flush(rx_flush),
    .push(rx_push), .push_data(rx_push_data), .pop(rx_rd),
    .head(rx_data), .full(rx_full), .empty(rx_empty)
  );

  ufc_status u_stat (
    .clk(clk), .rst_n(srst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .tx_overflow(tx_wr & tx_full), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_pin_idle(rx_pin_idle),
    .flow_xon(flow_xon), .reg_rdata(reg_rdata), .tx_flush(tx_flush),
    .rx_flush(rx_flush), .stop_mode(stop_mode)
  );

  ufc_irq_sel u_irq (
    .clk(clk), .rst_n(srst_n), .stop_mode(stop_mode), .stop_cfg(stop_cfg),
    .stb_mid_first(stb_mid_first), .stb_end_first(stb_end_first),
    .stb_end_last(stb_end_last), .rx_irq(rx_irq)
  );

  assign shf_load  = shf_ready & ~tx_empty & ~tx_flush;
  assign shf_clear = tx_flush;
endmodule

// File: rtl/ufc_checker.sv
module ufc_checker (
  input logic       clk,
  input logic       srst_n,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       tx_wr,
  input logic       shf_ready,
  input logic       shf_load,
  input logic       shf_clear,
  input logic       stb_mid_first,
  input logic       rx_irq
);
  assert_tx_flags_excl_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !(reg_rdata[5] && reg_rdata[4]));

  assert_overflow_sets_err_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_wr && reg_rdata[4]) |=> reg_rdata[7]);

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_rdata[7] && !reg_we) |=> reg_rdata[7]);

  assert_flush_clears_shifter_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_we && reg_wdata[5]) |-> (shf_clear && !shf_load));

  assert_flush_empties_tx_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_we && reg_wdata[5]) |=> reg_rdata[5]);

  assert_load_needs_data_R5: assert property (@(posedge clk) disable iff (!srst_n)
    shf_load |-> (shf_ready && !reg_rdata[5]));

  assert_flush_empties_rx_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_we && reg_wdata[1]) |=> reg_rdata[1]);

  assert_irq_mid_mode_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !reg_rdata[6] |=> (rx_irq == $past(stb_mid_first)));
endmodule

bind uart_bufctl ufc_checker u_ufc_checker (
  .clk(clk), .srst_n(srst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .tx_wr(tx_wr), .shf_ready(shf_ready),
  .shf_load(shf_load), .shf_clear(shf_clear),
  .stb_mid_first(stb_mid_first), .rx_irq(rx_irq)
);

// File: tb/uart_bufctl_bench.sv
module uart_bufctl_bench;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk; // 8 ns period, 125 MHz

  logic rst_n, reg_we, tx_wr, shf_ready, rx_push, rx_rd, rx_pin_idle, flow_xon;
  logic stb_mid_first, stb_end_first, stb_end_last;
  logic [7:0] reg_wdata, tx_data, rx_push_data;
  logic [1:0] stop_cfg;
  logic [7:0] reg_rdata, shf_data, rx_data;
  logic shf_load, shf_clear, rx_irq;

  uart_bufctl u_uart_bufctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_wr(tx_wr), .tx_data(tx_data),
    .shf_ready(shf_ready), .shf_load(shf_load), .shf_data(shf_data),
    .shf_clear(shf_clear), .rx_push(rx_push), .rx_push_data(rx_push_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_pin_idle(rx_pin_idle),
    .flow_xon(flow_xon), .stop_cfg(stop_cfg), .stb_mid_first(stb_mid_first),
    .stb_end_first(stb_end_first), .stb_end_last(stb_end_last), .rx_irq(rx_irq)
  );

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic m_err, m_mode, m_idle, m_xon, m_irq;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int tn, rn;
    logic ftx, frx, sel;
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_err = 1'b0; m_mode = 1'b0; m_idle = 1'b1; m_xon = 1'b1; m_irq = 1'b0;
    end else begin
      tn  = txq.size();
      rn  = rxq.size();
      ftx = reg_we && reg_wdata[5];
      frx = reg_we && reg_wdata[1];
      if (!m_mode)              sel = stb_mid_first;
      else if (stop_cfg == 2'b11) sel = stb_end_first;
      else                      sel = stb_end_last;
      m_irq = sel;
      if (tx_wr && tn == DEPTH) m_err = 1'b1;
      else if (reg_we)          m_err = reg_wdata[7];
      if (reg_we) m_mode = reg_wdata[6];
      if (ftx) txq.delete();
      else begin
        if (tn > 0 && shf_ready) void'(txq.pop_front());
        if (tx_wr && tn < DEPTH) txq.push_back(tx_data);
      end
      if (frx) rxq.delete();
      else begin
        if (rn > 0 && rx_rd) void'(rxq.pop_front());
        if (rx_push && rn < DEPTH) rxq.push_back(rx_push_data);
      end
      m_idle = rx_pin_idle;
      m_xon  = flow_xon;
    end
  end

  always @(negedge clk) begin
    logic ftx, ld;
    if (rst_n) begin
      ftx = reg_we && reg_wdata[5];
      ld  = (txq.size() > 0) && shf_ready && !ftx;
      chk("R3 write error bit", {7'd0, reg_rdata[7]}, {7'd0, m_err});
      chk("R10 stop mode bit", {7'd0, reg_rdata[6]}, {7'd0, m_mode});
      chk("R2 R4 tx empty bit", {7'd0, reg_rdata[5]}, {7'd0, txq.size() == 0});
      chk("R2 tx full bit", {7'd0, reg_rdata[4]}, {7'd0, txq.size() == DEPTH});
      chk("R9 rx idle bit", {7'd0, reg_rdata[3]}, {7'd0, m_idle});
      chk("R9 tx enable bit", {7'd0, reg_rdata[2]}, {7'd0, m_xon});
      chk("R6 R7 rx empty bit", {7'd0, reg_rdata[1]}, {7'd0, rxq.size() == 0});
      chk("R6 rx full bit", {7'd0, reg_rdata[0]}, {7'd0, rxq.size() == DEPTH});
      chk("R5 load strobe", {7'd0, shf_load}, {7'd0, ld});
      if (ld) chk("R5 load data", shf_data, txq[0]);
      chk("R4 shifter clear", {7'd0, shf_clear}, {7'd0, ftx});
      if (rxq.size() > 0) chk("R6 rx head data", rx_data, rxq[0]);
      chk("R8 rx interrupt", {7'd0, rx_irq}, {7'd0, m_irq});
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    tx_wr = 0; reg_we = 0; rx_push = 0; rx_rd = 0;
    stb_mid_first = 0; stb_end_first = 0; stb_end_last = 0;
  endtask

  task automatic wr_reg(input logic [7:0] v);
    reg_we = 1; reg_wdata = v; cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_wdata = 0; tx_wr = 0; tx_data = 0; shf_ready = 0;
    rx_push = 0; rx_push_data = 0; rx_rd = 0; rx_pin_idle = 1; flow_xon = 1;
    stop_cfg = 0; stb_mid_first = 0; stb_end_first = 0; stb_end_last = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) cyc();
    @(negedge clk);
    chk("R1 reset value", reg_rdata, 8'h2E);

    // R2 R3: fill TX, overflow, error stays set
    tx_wr = 1; tx_data = 8'hA1; cyc();
    tx_wr = 1; tx_data = 8'hB2; cyc();
    tx_wr = 1; tx_data = 8'hC3; cyc();
    repeat (2) cyc();
    @(negedge clk);
    chk("R3 error sticky", {7'd0, reg_rdata[7]}, 8'd1);
    wr_reg(8'h00);
    // R5: drain in order
    shf_ready = 1; repeat (3) cyc(); shf_ready = 0;

    // R3 overflow during a load at full, R4 zero write then flush
    tx_wr = 1; tx_data = 8'h11; cyc();
    tx_wr = 1; tx_data = 8'h22; cyc();
    shf_ready = 1; tx_wr = 1; tx_data = 8'h33; cyc(); shf_ready = 0;
    tx_wr = 1; tx_data = 8'h44; cyc();
    wr_reg(8'h00);
    shf_ready = 1; reg_we = 1; reg_wdata = 8'h20; tx_wr = 1; tx_data = 8'h55; cyc();
    shf_ready = 0; cyc();
    @(negedge clk);
    chk("R4 tx empty after flush", {7'd0, reg_rdata[5]}, 8'd1);

    // R6 R7: RX fill, drop, read, zero write, flush
    rx_push = 1; rx_push_data = 8'h61; cyc();
    rx_push = 1; rx_push_data = 8'h62; cyc();
    rx_push = 1; rx_push_data = 8'h63; cyc();
    @(negedge clk);
    chk("R6 rx head kept after drop", rx_data, 8'h61);
    rx_rd = 1; cyc();
    rx_rd = 1; rx_push = 1; rx_push_data = 8'h64; cyc();
    wr_reg(8'h00);
    rx_push = 1; rx_push_data = 8'h65; cyc();
    reg_we = 1; reg_wdata = 8'h02; rx_push = 1; rx_push_data = 8'h66; rx_rd = 1; cyc();
    cyc();

    // R8: every mode, configuration and strobe
    for (int m = 0; m < 2; m++) begin
      wr_reg({1'b0, m[0], 6'd0});
      for (int c = 0; c < 4; c++) begin
        stop_cfg = c[1:0];
        stb_mid_first = 1; cyc(); cyc();
        stb_end_first = 1; cyc(); cyc();
        stb_end_last = 1; cyc(); cyc();
      end
    end

    // R9: line inputs and writes to read-only fields
    rx_pin_idle = 0; cyc(); flow_xon = 0; cyc();
    wr_reg(8'h9D); cyc();
    rx_pin_idle = 1; flow_xon = 1; cyc();
    wr_reg(8'h00);

    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      tx_wr = ($urandom % 3) == 0; tx_data = 8'($urandom);
      shf_ready = ($urandom % 3) == 0;
      rx_push = ($urandom % 3) == 0; rx_push_data = 8'($urandom);
      rx_rd = ($urandom % 3) == 0;
      reg_we = ($urandom % 10) == 0; reg_wdata = 8'($urandom);
      rx_pin_idle = ($urandom % 4) != 0; flow_xon = ($urandom % 4) != 0;
      stop_cfg = 2'($urandom);
      stb_mid_first = ($urandom % 4) == 0; stb_end_first = ($urandom % 4) == 0;
      stb_end_last = ($urandom % 4) == 0;
      cyc();
    end
    shf_ready = 0;
    repeat (3) cyc();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule